// File: doc/BRIEF.md
# Packed integer dot-product accumulate unit

This block is a SIMD datapath that runs a small dot product with accumulate separately in every 32-bit lane of a vector. Each lane takes its slice of an accumulator vector and two source vectors. It multiplies narrow elements of the two sources pairwise, adds the products to the accumulator slice, and can clamp the total to the signed 32-bit range. The lane results then pass through a per-lane write mask. Under that mask, a lane that is not written either keeps its accumulator value or becomes zero.

The port vectors always carry `PORT_LANES` lanes. The parameter `LANES` (four or eight) sets how many of them are active, and every lane at or above `LANES` returns zero. The unit captures a new operation when `in_valid` is high. It presents the result with `out_valid` after the next rising clock edge. The result holds until the next strobe.

Top module: `dot_acc_unit`

## Requirements
- R1: With `op` = 2'b00 (byte, wrapping), lane j returns acc[j] + sum over k=0..3 of (unsigned byte k of a[j]) × (signed byte k of b[j]), modulo 2^32. Byte k occupies bits 8k+7:8k of the lane.
- R2: With `op` = 2'b10 (word, wrapping), lane j returns acc[j] + sum over k=0..1 of (signed word k of a[j]) × (signed word k of b[j]), modulo 2^32. Word k occupies bits 16k+15:16k. For example, two products of (-32768)·(-32768) on a zero accumulator give 0x80000000.
- R3: With `op` = 2'b01 (byte, saturating) or 2'b11 (word, saturating), an exact total above 2^31-1 returns 0x7FFFFFFF. An exact total inside the signed 32-bit range is returned unchanged.
- R4: In the saturating forms, an exact total below -2^31 returns 0x80000000.
- R5: When `wmask[j]` = 0 and `zero_mask` = 0 (merge), lane j of the result equals lane j of `acc_in`.
- R6: When `wmask[j]` = 0 and `zero_mask` = 1, lane j of the result is zero.
- R7: Result lanes j ≥ `LANES` are always zero, whatever the inputs and the mask.
- R8: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `result` changes only on a clock edge where `in_valid` is high.
- R9: While `rst_n` is low, `result` and `out_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `clk` |
| in_valid | input | 1 | Capture strobe for the operands below |
| op | input | 2 | Bit 1: 0 byte, 1 word. Bit 0: 0 wrap, 1 saturate |
| zero_mask | input | 1 | 0 merges the accumulator into unwritten lanes, 1 zeroes them |
| wmask | input | PORT_LANES | Per-lane write enable, bit j for lane j |
| acc_in | input | 32·PORT_LANES | Accumulator vector, lane j at bits 32j+31:32j |
| a_in | input | 32·PORT_LANES | First source (unsigned bytes or signed words) |
| b_in | input | 32·PORT_LANES | Second source (signed bytes or signed words) |
| out_valid | output | 1 | Result is fresh this cycle |
| result | output | 32·PORT_LANES | Registered result vector |

## Verification
The bench sets every byte of the first source to 255 and every byte of the second to -128. A design that sign-extends the first operand, or sums the products in 16 bits, gives a small or positive total here instead of -130560. The word case (-32768)² twice must wrap to 0x80000000; a design that saturates in the wrapping form, or drops the carry, gets this wrong. The bench also adds a positive total to the largest accumulator and a negative total to the most negative one, in both forms. A clamp built on a 32-bit sum would miss the overflow and return a wrapped value, and a clamp with the limits swapped would return the wrong one. Merge, zero and inactive-lane cases are mixed within one vector, so a mask routed to the wrong lane, or treated as the wrong polarity, shows up as a lane mismatch.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  localparam int LANE_W   = 32;
  localparam int BYTE_N   = 4;
  localparam int WORD_N   = 2;
  localparam int BPROD_W  = 17;
  localparam int WPROD_W  = 32;
  localparam int SUM_W    = 36;

  typedef enum logic [1:0] {
    OP_BYTE_WRAP = 2'b00,
    OP_BYTE_SAT  = 2'b01,
    OP_WORD_WRAP = 2'b10,
    OP_WORD_SAT  = 2'b11
  } dpa_op_e;

  function automatic logic op_is_word(input logic [1:0] op);
    return op[1];
  endfunction

  function automatic logic op_is_sat(input logic [1:0] op);
    return op[0];
  endfunction
endpackage

// File: rtl/dpa_dot.sv
module dpa_dot
  import dpa_pkg::*;
(
  input  logic                     word_mode,
  input  logic [LANE_W-1:0]        src_a,
  input  logic [LANE_W-1:0]        src_b,
  output logic signed [SUM_W-1:0]  dot
);
  logic signed [BPROD_W-1:0] bprod [BYTE_N];
  logic signed [WPROD_W-1:0] wprod [WORD_N];
  logic signed [SUM_W-1:0]   byte_sum;
  logic signed [SUM_W-1:0]   word_sum;

  // unsigned byte of A (zero-extended) times signed byte of B
  for (genvar k = 0; k < BYTE_N; k++) begin : g_byte
    assign bprod[k] = $signed({1'b0, src_a[8*k +: 8]}) * $signed(src_b[8*k +: 8]);
  end

  for (genvar k = 0; k < WORD_N; k++) begin : g_word
    assign wprod[k] = $signed(src_a[16*k +: 16]) * $signed(src_b[16*k +: 16]);
  end

  always_comb begin
    byte_sum = '0;
    for (int k = 0; k < BYTE_N; k++) begin
      byte_sum = byte_sum + {{(SUM_W-BPROD_W){bprod[k][BPROD_W-1]}}, bprod[k]};
    end
  end

  always_comb begin
    word_sum = '0;
    for (int k = 0; k < WORD_N; k++) begin
      word_sum = word_sum + {{(SUM_W-WPROD_W){wprod[k][WPROD_W-1]}}, wprod[k]};
    end
  end

  assign dot = word_mode ? word_sum : byte_sum;
endmodule

// File: rtl/dpa_clamp.sv
module dpa_clamp
  import dpa_pkg::*;
(
  input  logic                    sat_en,
  input  logic signed [SUM_W-1:0] wide,
  output logic [LANE_W-1:0]       res
);
  localparam logic signed [SUM_W-1:0] HI = {{(SUM_W-LANE_W+1){1'b0}}, {(LANE_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] LO = {{(SUM_W-LANE_W+1){1'b1}}, {(LANE_W-1){1'b0}}};

  always_comb begin
    res = wide[LANE_W-1:0];
    if (sat_en) begin
      if (wide > HI)      res = {1'b0, {(LANE_W-1){1'b1}}};
      else if (wide < LO) res = {1'b1, {(LANE_W-1){1'b0}}};
    end
  end
endmodule

// File: rtl/dpa_lane.sv
module dpa_lane
  import dpa_pkg::*;
(
  input  logic [1:0]        op,
  input  logic [LANE_W-1:0] acc,
  input  logic [LANE_W-1:0] src_a,
  input  logic [LANE_W-1:0] src_b,
  output logic [LANE_W-1:0] res
);
  logic signed [SUM_W-1:0] dot;
  logic signed [SUM_W-1:0] wide;

  dpa_dot u_dot (
    .word_mode (op_is_word(op)),
    .src_a     (src_a),
    .src_b     (src_b),
    .dot       (dot)
  );

  assign wide = {{(SUM_W-LANE_W){acc[LANE_W-1]}}, acc} + dot;

  dpa_clamp u_clamp (
    .sat_en (op_is_sat(op)),
    .wide   (wide),
    .res    (res)
  );
endmodule

// File: rtl/dot_acc_unit.sv
module dot_acc_unit
  import dpa_pkg::*;
#(
  parameter int PORT_LANES = 8,
  parameter int LANES      = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [1:0]                   op,
  input  logic                         zero_mask,
  input  logic [PORT_LANES-1:0]        wmask,
  input  logic [PORT_LANES*32-1:0]     acc_in,
  input  logic [PORT_LANES*32-1:0]     a_in,
  input  logic [PORT_LANES*32-1:0]     b_in,
  output logic                         out_valid,
  output logic [PORT_LANES*32-1:0]     result
);
  localparam int VEC_W = PORT_LANES * LANE_W;

  logic [VEC_W-1:0] nxt_result;
  logic             nxt_valid;

  for (genvar j = 0; j < PORT_LANES; j++) begin : g_lane
    logic [LANE_W-1:0] sel;
    if (j < LANES) begin : g_act
      logic [LANE_W-1:0] acc_j;
      logic [LANE_W-1:0] calc;
      assign acc_j = acc_in[j*LANE_W +: LANE_W];
      dpa_lane u_lane (
        .op    (op),
        .acc   (acc_j),
        .src_a (a_in[j*LANE_W +: LANE_W]),
        .src_b (b_in[j*LANE_W +: LANE_W]),
        .res   (calc)
      );
      assign sel = wmask[j] ? calc : (zero_mask ? '0 : acc_j);

      // R5: unwritten lane in merge mode keeps accumulator
      p_merge_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !zero_mask && !wmask[j]) |=>
          (result[j*LANE_W +: LANE_W] == $past(acc_in[j*LANE_W +: LANE_W])));
      // R6: unwritten lane in zero mode reads zero
      p_zero_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && zero_mask && !wmask[j]) |=> (result[j*LANE_W +: LANE_W] == '0));
    end else begin : g_off
      assign sel = '0;
      // R7: lanes beyond the active width stay zero
      p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (result[j*LANE_W +: LANE_W] == '0));
    end
    assign nxt_result[j*LANE_W +: LANE_W] = sel;
  end

  assign nxt_valid = in_valid;

  // reset is synchronised upstream; assertion edge is asynchronous
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= nxt_valid;
      if (in_valid) result <= nxt_result;
    end
  end

  // R8: valid follows strobe by one edge, result holds otherwise
  p_valid_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
endmodule

// File: tb/dot_acc_unit_tb.sv
module dot_acc_unit_tb;
  import dpa_pkg::*;

  localparam int PL    = 8;
  localparam int LN    = 4;
  localparam int VW    = PL * 32;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [1:0]    op;
  logic          zero_mask;
  logic [PL-1:0] wmask;
  logic [VW-1:0] acc_in, a_in, b_in;
  logic          out_valid;
  logic [VW-1:0] result;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  dot_acc_unit #(.PORT_LANES(PL), .LANES(LN)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .zero_mask(zero_mask), .wmask(wmask), .acc_in(acc_in),
    .a_in(a_in), .b_in(b_in), .out_valid(out_valid), .result(result)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] model(input logic [1:0] o, input logic [31:0] s,
                                        input logic [31:0] a, input logic [31:0] b);
    longint t;
    t = longint'($signed(s));
    if (!o[1]) begin
      for (int k = 0; k < 4; k++)
        t += longint'(a[8*k +: 8]) * longint'($signed(b[8*k +: 8]));
    end else begin
      for (int k = 0; k < 2; k++)
        t += longint'($signed(a[16*k +: 16])) * longint'($signed(b[16*k +: 16]));
    end
    if (o[0]) begin
      if (t > 64'sd2147483647)  t = 64'sd2147483647;
      if (t < -64'sd2147483648) t = -64'sd2147483648;
    end
    return t[31:0];
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  // drive one operation, then check every lane and the valid flag
  task automatic apply(input string tag, input logic [1:0] o, input logic zm,
                       input logic [PL-1:0] wm, input logic [VW-1:0] s,
                       input logic [VW-1:0] a, input logic [VW-1:0] b);
    logic [31:0] exp;
    @(negedge clk);
    op = o; zero_mask = zm; wmask = wm; acc_in = s; a_in = a; b_in = b;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R8 valid"}, {31'b0, out_valid}, 32'd1);
    for (int j = 0; j < PL; j++) begin
      if (j >= LN)       exp = '0;
      else if (wm[j])    exp = model(o, s[32*j +: 32], a[32*j +: 32], b[32*j +: 32]);
      else if (zm)       exp = '0;
      else               exp = s[32*j +: 32];
      check($sformatf("%s lane%0d", tag, j), result[32*j +: 32], exp);
    end
  endtask

  function automatic logic [VW-1:0] fill(input logic [31:0] base, input logic [31:0] step);
    logic [VW-1:0] v;
    for (int j = 0; j < PL; j++) v[32*j +: 32] = base + step * j;
    return v;
  endfunction

  task automatic t_reset_r9();
    check("R9 reset valid", {31'b0, out_valid}, 32'd0);
    for (int j = 0; j < PL; j++) check("R9 reset result", result[32*j +: 32], 32'd0);
  endtask

  task automatic t_byte_wrap_r1();
    apply("R1 byte mix", OP_BYTE_WRAP, 1'b0, '1,
          fill(32'h0000_1234, 32'h1111_0000), fill(32'h11F2_3384, 32'h0102_0304),
          fill(32'h7F80_01FF, 32'h0311_2233));
    apply("R1 byte corner", OP_BYTE_WRAP, 1'b0, '1, '0, {PL{32'hFFFF_FFFF}},
          {PL{32'h8080_8080}});
    check("R1 corner value", result[31:0], 32'hFFFE_0200);
  endtask

  task automatic t_word_wrap_r2();
    apply("R2 word mix", OP_WORD_WRAP, 1'b0, '1,
          fill(32'hFFFF_FF00, 32'h0000_0101), fill(32'h8001_7FFF, 32'h0003_0100),
          fill(32'h1234_F00F, 32'h0100_0007));
    apply("R2 word wrap", OP_WORD_WRAP, 1'b0, '1, '0, {PL{32'h8000_8000}},
          {PL{32'h8000_8000}});
    check("R2 wrap value", result[31:0], 32'h8000_0000);
  endtask

  task automatic t_sat_hi_r3();
    apply("R3 byte max wrap", OP_BYTE_WRAP, 1'b0, '1, {PL{32'h7FFF_FFFF}},
          {PL{32'h0101_0101}}, {PL{32'h0101_0101}});
    check("R3 byte wrap value", result[31:0], 32'h8000_0003);
    apply("R3 byte max sat", OP_BYTE_SAT, 1'b0, '1, {PL{32'h7FFF_FFFF}},
          {PL{32'h0101_0101}}, {PL{32'h0101_0101}});
    check("R3 byte sat value", result[31:0], 32'h7FFF_FFFF);
    apply("R3 word sat", OP_WORD_SAT, 1'b0, '1, '0, {PL{32'h8000_8000}},
          {PL{32'h8000_8000}});
    check("R3 word sat value", result[31:0], 32'h7FFF_FFFF);
    apply("R3 in range", OP_BYTE_SAT, 1'b0, '1, fill(32'h0000_0010, 32'h0000_0100),
          fill(32'hFFFF_FFFF, 32'h0), {PL{32'h8080_8080}});
  endtask

  task automatic t_sat_lo_r4();
    apply("R4 byte min wrap", OP_BYTE_WRAP, 1'b0, '1, {PL{32'h8000_0000}},
          {PL{32'hFFFF_FFFF}}, {PL{32'h8080_8080}});
    check("R4 byte wrap value", result[31:0], 32'h7FFE_0200);
    apply("R4 byte min sat", OP_BYTE_SAT, 1'b0, '1, {PL{32'h8000_0000}},
          {PL{32'hFFFF_FFFF}}, {PL{32'h8080_8080}});
    check("R4 byte sat value", result[31:0], 32'h8000_0000);
    apply("R4 word min sat", OP_WORD_SAT, 1'b0, '1, {PL{32'h8000_0000}},
          {PL{32'h7FFF_7FFF}}, {PL{32'h8000_8000}});
    check("R4 word sat value", result[31:0], 32'h8000_0000);
    apply("R4 word min wrap", OP_WORD_WRAP, 1'b0, '1, {PL{32'h8000_0000}},
          {PL{32'h7FFF_7FFF}}, {PL{32'h8000_8000}});
  endtask

  task automatic t_merge_r5();
    apply("R5 merge", OP_BYTE_SAT, 1'b0, 8'b1010_0101, fill(32'hCAFE_0001, 32'h0000_1001),
          fill(32'h0A0B_0C0D, 32'h0101_0101), fill(32'hF1F2_0304, 32'h0001_0000));
    check("R5 lane1 kept", result[63:32], 32'hCAFE_1002);
  endtask

  task automatic t_zero_r6();
    apply("R6 zero", OP_WORD_SAT, 1'b1, 8'b0101_0110, fill(32'h5555_0001, 32'h0000_0003),
          fill(32'h0102_0304, 32'h0001_0001), fill(32'hFFFE_0005, 32'h0002_0000));
    check("R6 lane0 zero", result[31:0], 32'h0);
  endtask

  task automatic t_upper_r7();
    apply("R7 upper", OP_BYTE_WRAP, 1'b0, '1, {PL{32'h1357_9BDF}},
          {PL{32'h0203_0405}}, {PL{32'h0607_0809}});
    for (int j = LN; j < PL; j++) check("R7 upper lane", result[32*j +: 32], 32'h0);
  endtask

  task automatic t_hold_r8();
    logic [VW-1:0] prev;
    apply("R8 base", OP_WORD_WRAP, 1'b0, '1, fill(32'h10, 32'h1),
          fill(32'h0002_0003, 32'h0), fill(32'h0004_0005, 32'h0));
    prev = result;
    @(negedge clk);
    acc_in = '1; a_in = '1; b_in = '1; wmask = '0; zero_mask = 1'b1;
    @(negedge clk);
    check("R8 idle valid", {31'b0, out_valid}, 32'd0);
    for (int j = 0; j < PL; j++) check("R8 hold", result[32*j +: 32], prev[32*j +: 32]);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = '0; zero_mask = 1'b0; wmask = '0;
    acc_in = '0; a_in = '0; b_in = '0;
    repeat (3) @(negedge clk);
    t_reset_r9();
    rst_n = 1'b1;
    t_byte_wrap_r1();
    t_word_wrap_r2();
    t_sat_hi_r3();
    t_sat_lo_r4();
    t_merge_r5();
    t_zero_r6();
    t_upper_r7();
    t_hold_r8();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule